// File: doc/BRIEF.md
# External Bus Yield Controller

This block sits on the bus-master side of an external memory bus and hands that bus to another device when asked. The other device pulls an active-low request line. That line is asynchronous, so it passes through a synchronizer first. The controller then lets any access already on the bus finish. After that it stops driving its five memory selects (program, data, control, I/O and boot), its read strobe, its write strobe and its address. Only once the bus is released does it pull its active-low grant line. When the requester lets go of the request, the grant rises first, and the controller drives the bus again one clock later.

The internal core reaches the bus through a valid/ready access port. A request is taken on a clock edge where both `core_valid` and `core_ready` are high. The core must hold `core_valid`, `core_sel`, `core_wr` and `core_addr` steady until that edge. `core_ready` is the only back-pressure. It is low while an access is running, while the bus is not owned, and while a synchronized external request is waiting. Each accepted access drives its strobes for `ACC_LEN` cycles, and `core_done` pulses in the next cycle. While the bus is granted away and the core is holding a request, the active-low `bus_hung_n` output tells the requester that the core is stalled waiting for the bus.

Top module: `ext_bus_yield`

## Requirements
- R1: While reset is held and just after it, `bus_grant_n`=1, `bus_drive`=1, `bus_hung_n`=1, `core_done`=0, `bus_rd_n`=`bus_wr_n`=1 and `bus_sel_n`=5'h1F.
- R2: With no access running, a request line low from cycle r (driven between edges) gives `bus_drive`=0 first in cycle r+SYNC_STAGES+1.
- R3: An access in progress is never cut short. If the access was accepted at edge a, `bus_drive` falls no earlier than cycle a+ACC_LEN+1, and all strobes are inactive in the cycle before it falls.
- R4: `bus_grant_n` falls exactly one cycle after `bus_drive` falls, and it is never low while `bus_drive`=1.
- R5: If the request line goes high in cycle q, `bus_grant_n` rises in cycle q+SYNC_STAGES+1 and `bus_drive` returns one cycle later. `bus_drive` never rises while the grant is low or in the same cycle the grant rises.
- R6: `bus_hung_n` is low exactly when `bus_grant_n` is low and `core_valid` is high.
- R7: While `bus_grant_n` is low, `core_ready`=0 and `core_done`=0. Once the bus is regained with no request pending, `core_ready` returns to 1.
- R8: During an access, `core_sel` codes 0..4 (program, data, control, I/O, boot) pull the matching bit of `bus_sel_n` low, and codes 5..7 pull none. `core_wr`=0 pulls `bus_rd_n` low and `core_wr`=1 pulls `bus_wr_n` low. The strobes are active in cycles a..a+ACC_LEN-1, and `core_done` is high only in cycle a+ACC_LEN. At most one select and at most one of read/write is ever active.
- R9: While `bus_drive`=0, every select and strobe stays high and `bus_addr` is 0.
- R10: An access is taken only on an edge with `core_valid` and `core_ready` both high. `bus_addr` shows the address captured at that edge for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Asynchronous active-low bus request from the other master |
| bus_grant_n | output | 1 | Active-low bus grant |
| bus_hung_n | output | 1 | Active-low: bus granted away and core waiting for it |
| bus_drive | output | 1 | Output enable for selects, strobes and address (0 = tri-stated at the pad) |
| bus_sel_n | output | 5 | Active-low memory selects: [0] program, [1] data, [2] control, [3] I/O, [4] boot |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | Bus address |
| core_valid | input | 1 | Core access request valid |
| core_ready | output | 1 | Controller accepts the access on this edge |
| core_sel | input | 3 | Target select code 0..7 |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Access address |
| core_done | output | 1 | One-cycle pulse when the access ends |

## Verification
A corrupted ownership state shows up at the ports within one cycle. A grant could appear while the bus is still driven, the bus could be re-driven under a live grant, or `core_ready` could rise while the bus is away. Each of these breaks an ordering rule in the very cycle it happens. A miscount in the synchronizer or the access counter does not break any ordering. Instead it moves the release, grant or done edge by a whole cycle, which the sweeps catch by comparing the cycle against one computed from the request time and the accept edge. A wrong select decode or address register shows on the bus pins during the access itself.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int NUM_SEL = 5;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    ST_OWN      = 2'd0,
    ST_DISABLE  = 2'd1,
    ST_GRANTED  = 2'd2,
    ST_REENABLE = 2'd3
  } own_state_t;
endpackage

// File: rtl/ebus_req_sync.sv
module ebus_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_active
);
  logic [STAGES-1:0] chain;

  // shift chain resets to the inactive (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], req_n_async};
  end

  assign req_active = ~chain[STAGES-1];
endmodule

// File: rtl/ebus_own_fsm.sv
module ebus_own_fsm
  import ebus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_active,
  input  logic       access_busy,
  output own_state_t state,
  output logic       grant_n,
  output logic       drive
);
  own_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OWN:      if (req_active && !access_busy) nxt = ST_DISABLE;
      ST_DISABLE:  nxt = ST_GRANTED;
      ST_GRANTED:  if (!req_active) nxt = ST_REENABLE;
      ST_REENABLE: nxt = ST_OWN;
      default:     nxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= nxt;
  end

  // outputs decoded straight from the state flops
  assign grant_n = (state != ST_GRANTED);
  assign drive   = (state == ST_OWN);
endmodule

// File: rtl/ebus_access_eng.sv
module ebus_access_eng
  import ebus_pkg::*;
#(
  parameter int ACC_LEN = 3,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               allow,
  input  logic               in_valid,
  input  logic [SEL_W-1:0]   in_sel,
  input  logic               in_wr,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               in_ready,
  output logic               busy,
  output logic               done,
  output logic [NUM_SEL-1:0] sel_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic [ADDR_W-1:0]  addr
);
  localparam int CW = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(ACC_LEN - 1);

  logic [CW-1:0]     cnt;
  logic [SEL_W-1:0]  cur_sel;
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic              take;

  assign in_ready = allow && !busy;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      cur_sel  <= '0;
      cur_wr   <= 1'b0;
      cur_addr <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy     <= 1'b1;
        cnt      <= LOAD;
        cur_sel  <= in_sel;
        cur_wr   <= in_wr;
        cur_addr <= in_addr;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // one decoder slice per memory select
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_n[g] = !(busy && (cur_sel == SEL_W'(g)));
  end

  assign rd_n = !(busy && !cur_wr);
  assign wr_n = !(busy && cur_wr);
  assign addr = busy ? cur_addr : '0;
endmodule

// File: rtl/ext_bus_yield.sv
module ext_bus_yield
  import ebus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACC_LEN     = 3,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_n,
  output logic              bus_grant_n,
  output logic              bus_hung_n,
  output logic              bus_drive,
  output logic [4:0]        bus_sel_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic [2:0]        core_sel,
  input  logic              core_wr,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              core_done
);
  logic               req_active;
  logic               busy;
  logic               allow;
  own_state_t         state;
  logic [NUM_SEL-1:0] raw_sel_n;
  logic               raw_rd_n;
  logic               raw_wr_n;
  logic [ADDR_W-1:0]  raw_addr;

  ebus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_async (bus_req_n),
    .req_active  (req_active)
  );

  ebus_own_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_active  (req_active),
    .access_busy (busy),
    .state       (state),
    .grant_n     (bus_grant_n),
    .drive       (bus_drive)
  );

  // new accesses only while owning and no yield is pending
  assign allow = (state == ST_OWN) && !req_active;

  ebus_access_eng #(.ACC_LEN(ACC_LEN), .ADDR_W(ADDR_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .allow    (allow),
    .in_valid (core_valid),
    .in_sel   (core_sel),
    .in_wr    (core_wr),
    .in_addr  (core_addr),
    .in_ready (core_ready),
    .busy     (busy),
    .done     (core_done),
    .sel_n    (raw_sel_n),
    .rd_n     (raw_rd_n),
    .wr_n     (raw_wr_n),
    .addr     (raw_addr)
  );

  assign bus_sel_n  = bus_drive ? raw_sel_n : '1;
  assign bus_rd_n   = bus_drive ? raw_rd_n  : 1'b1;
  assign bus_wr_n   = bus_drive ? raw_wr_n  : 1'b1;
  assign bus_addr   = bus_drive ? raw_addr  : '0;
  assign bus_hung_n = !((state == ST_GRANTED) && core_valid);
endmodule

// File: rtl/ext_bus_yield_chk.sv
module ext_bus_yield_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_grant_n,
  input logic       bus_hung_n,
  input logic       bus_drive,
  input logic [4:0] bus_sel_n,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       core_valid,
  input logic       core_ready,
  input logic       core_done
);
  // R4
  grant_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> !bus_drive);

  // R4
  grant_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> $past(!bus_drive));

  // R5
  redrive_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> (bus_grant_n && $past(bus_grant_n)));

  // R3
  release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive) |-> $past(bus_rd_n && bus_wr_n && (&bus_sel_n)));

  // R6
  hung_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hung_n |-> (!bus_grant_n && core_valid));

  // R6
  hung_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && core_valid) |-> !bus_hung_n);

  // R7
  granted_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> (!core_ready && !core_done));

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_sel_n) && $onehot0({~bus_rd_n, ~bus_wr_n}));

  // R9
  undriven_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_rd_n && bus_wr_n && (&bus_sel_n)));
endmodule

bind ext_bus_yield ext_bus_yield_chk u_chk (.*);

// File: tb/ext_bus_yield_test.sv
`timescale 1ns/1ps
module ext_bus_yield_test;
  localparam int SYNC = 2;
  localparam int ACC  = 3;
  localparam int AW   = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req_n;
  logic          bus_grant_n, bus_hung_n, bus_drive, bus_rd_n, bus_wr_n;
  logic [4:0]    bus_sel_n;
  logic [AW-1:0] bus_addr;
  logic          core_valid, core_ready, core_wr, core_done;
  logic [2:0]    core_sel;
  logic [AW-1:0] core_addr;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_bus_yield #(.SYNC_STAGES(SYNC), .ACC_LEN(ACC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n),
    .bus_grant_n(bus_grant_n), .bus_hung_n(bus_hung_n), .bus_drive(bus_drive),
    .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .core_valid(core_valid), .core_ready(core_ready),
    .core_sel(core_sel), .core_wr(core_wr), .core_addr(core_addr),
    .core_done(core_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_sel(input int s);
    return (s < 5) ? (~(1 << s) & 5'h1F) : 5'h1F;
  endfunction

  // one access with full strobe and done checks
  task automatic do_access(input int s, input int w);
    int a;
    @(negedge clk);
    core_valid = 1'b1; core_sel = 3'(s); core_wr = w[0];
    core_addr = AW'(16'hA000 + s * 16 + w);
    chk(core_ready == 1'b1, "R10", "ready when idle", core_ready, 1);
    @(negedge clk);
    a = cyc;
    core_valid = 1'b0;
    for (int i = 0; i < ACC; i++) begin
      chk(bus_sel_n == 5'(exp_sel(s)), "R8", "select decode", bus_sel_n, exp_sel(s));
      chk(bus_rd_n == w[0] && bus_wr_n == !w[0], "R8", "rd/wr strobe",
          {bus_rd_n, bus_wr_n}, {w[0], !w[0]});
      chk(bus_addr == AW'(16'hA000 + s * 16 + w), "R10", "captured address",
          bus_addr, 16'hA000 + s * 16 + w);
      chk(core_done == 1'b0, "R8", "done low during access", core_done, 0);
      @(negedge clk);
    end
    chk(cyc == a + ACC && core_done == 1'b1, "R8", "done pulse", core_done, 1);
    chk(bus_rd_n && bus_wr_n && bus_sel_n == 5'h1F, "R8", "strobes end", bus_sel_n, 31);
    @(negedge clk);
    chk(core_done == 1'b0, "R8", "done single cycle", core_done, 0);
  endtask

  // request / grant / release cycle, optionally behind a running access
  task automatic grant_cycle(input int k, input bit with_acc);
    int a, r, q, fd, fg, fg2, fd2, exp_d;
    bit ord_ok;
    a = -100;
    if (with_acc) begin
      @(negedge clk);
      core_valid = 1'b1; core_sel = 3'(k % 5); core_wr = k[0];
      core_addr = AW'(k);
      @(negedge clk);
      a = cyc;
      core_valid = 1'b0;
    end
    repeat (k) @(negedge clk);
    r = cyc;
    bus_req_n = 1'b0;
    exp_d = (r + SYNC + 1 > a + ACC + 1) ? r + SYNC + 1 : a + ACC + 1;
    fd = -1; fg = -1; ord_ok = 1'b1;
    for (int i = 0; i < 30 && fg < 0; i++) begin
      @(negedge clk);
      if (!bus_grant_n && bus_drive) ord_ok = 1'b0;
      if (fd < 0 && !bus_drive) fd = cyc;
      if (fg < 0 && !bus_grant_n) fg = cyc;
    end
    if (with_acc) chk(fd == exp_d, "R3", "release after access", fd, exp_d);
    else          chk(fd == exp_d, "R2", "release latency", fd, exp_d);
    chk(fg == fd + 1, "R4", "grant one cycle after release", fg, fd + 1);
    chk(ord_ok, "R4", "grant only while undriven", ord_ok, 1);
    chk(bus_sel_n == 5'h1F && bus_rd_n && bus_wr_n && bus_addr == '0, "R9",
        "quiet while granted", bus_addr, 0);
    chk(bus_hung_n == 1'b1, "R6", "no hung without core request", bus_hung_n, 1);
    core_valid = 1'b1; core_sel = 3'd1; core_wr = 1'b0; core_addr = AW'(16'h0055);
    repeat (2) begin
      @(negedge clk);
      chk(bus_hung_n == 1'b0, "R6", "hung while core waits", bus_hung_n, 0);
      chk(!core_ready && !core_done, "R7", "core held off", core_ready, 0);
    end
    q = cyc;
    bus_req_n = 1'b1;
    fg2 = -1; fd2 = -1;
    for (int i = 0; i < 30 && fd2 < 0; i++) begin
      @(negedge clk);
      if (fg2 < 0 && bus_grant_n) begin
        fg2 = cyc;
        chk(bus_hung_n == 1'b1, "R6", "hung released with grant", bus_hung_n, 1);
        chk(bus_drive == 1'b0, "R5", "still undriven at grant rise", bus_drive, 0);
      end
      if (fd2 < 0 && bus_drive) fd2 = cyc;
    end
    chk(fg2 == q + SYNC + 1, "R5", "grant rise latency", fg2, q + SYNC + 1);
    chk(fd2 == fg2 + 1, "R5", "redrive after grant", fd2, fg2 + 1);
    chk(core_ready == 1'b1, "R7", "ready after regain", core_ready, 1);
    @(negedge clk);
    core_valid = 1'b0;
    chk(bus_addr == AW'(16'h0055) && bus_sel_n == 5'b11101, "R10",
        "held access runs after regain", bus_addr, 16'h0055);
    repeat (ACC + 3) @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0; bus_req_n = 1'b1; core_valid = 1'b0;
    core_sel = '0; core_wr = 1'b0; core_addr = '0;
    repeat (3) @(negedge clk);
    chk(bus_grant_n && bus_drive && bus_hung_n && !core_done, "R1", "reset outputs",
        {bus_grant_n, bus_drive, bus_hung_n, core_done}, 4'b1110);
    chk(bus_rd_n && bus_wr_n && bus_sel_n == 5'h1F, "R1", "reset strobes", bus_sel_n, 31);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_grant_n && bus_drive && bus_sel_n == 5'h1F, "R1", "after reset",
        bus_sel_n, 31);
    // sweep every select code with read and write
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++)
        do_access(s, w);
    // request at several offsets, idle and behind an access
    for (int k = 0; k < 3; k++) grant_cycle(k, 1'b0);
    for (int k = 0; k < 7; k++) grant_cycle(k, 1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule